// File: doc/BRIEF.md
# Adder-Subtractor with Condition Codes

A purely combinational arithmetic unit of parameterised width (32 bits by default). It adds or subtracts two operands that may be read as unsigned or as two's-complement values. The subtract select inverts the B operand and feeds a carry-in of one into the same carry network, so a single adder serves both operations. The carry network computes carries by lookahead inside fixed-size groups and chains the group carries.

Beside the result, the unit drives four condition bits: zero, negative, carry and overflow. From those four bits it forms ten compare outputs, six for signed and four for unsigned ordering. The compare outputs only carry meaning while the subtract select is high. A user places the unit in a datapath and registers its outputs outside it.

Top module: `addsub_cc`

## Requirements
- R1: With sub_i low, res_o equals (a_i + b_i) modulo 2^W.
- R2: With sub_i high, res_o equals (a_i - b_i) modulo 2^W, formed as a_i + ~b_i + 1.
- R3: z_o is 1 exactly when every bit of res_o is 0.
- R4: n_o equals res_o[W-1].
- R5: c_o is the carry out of the top bit of the internal sum. When adding, that is the unsigned overflow. When subtracting, it is 1 exactly when a_i >= b_i as unsigned values.
- R6: v_o is 1 exactly when the true two's-complement sum or difference of a_i and b_i lies outside [-2^(W-1), 2^(W-1)-1].
- R7: With sub_i high, lt_o, le_o, ge_o and gt_o give the signed ordering of a_i against b_i, derived from n_o xor v_o and z_o.
- R8: With sub_i high, eq_o is 1 exactly when a_i equals b_i, and ne_o is its inverse.
- R9: With sub_i high, ltu_o, leu_o, geu_o and gtu_o give the unsigned ordering of a_i against b_i, derived from c_o and z_o.
- R10: R1 to R9 hold at every width W that is a multiple of the group size GRP, including W = 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| sub_i | input | 1 | 1 selects a_i - b_i, 0 selects a_i + b_i |
| res_o | output | W | Sum or difference |
| z_o | output | 1 | Result is zero |
| n_o | output | 1 | Result sign bit |
| c_o | output | 1 | Carry out of the top bit |
| v_o | output | 1 | Signed overflow |
| lt_o | output | 1 | Signed less than |
| le_o | output | 1 | Signed less or equal |
| eq_o | output | 1 | Equal |
| ne_o | output | 1 | Not equal |
| ge_o | output | 1 | Signed greater or equal |
| gt_o | output | 1 | Signed greater than |
| ltu_o | output | 1 | Unsigned less than |
| leu_o | output | 1 | Unsigned less or equal |
| geu_o | output | 1 | Unsigned greater or equal |
| gtu_o | output | 1 | Unsigned greater than |

## Verification
The unit holds no state, so any fault in a group carry or a lookahead prefix shows in res_o and c_o during the same evaluation that applies the faulting operands. Such a fault only shows for operands whose carry passes through the broken group. For that reason the 4-bit instance is driven with every operand pair in both modes, and the 32-bit instance gets long carry chains that cross each group boundary. A missed inversion in the overflow term or a swapped compare formula shows on the very next vector whose operand signs or ordering exercise it. The sign-boundary and equal-operand vectors therefore appear in both instances.

// File: rtl/addsub_cc_pkg.sv
package addsub_cc_pkg;
  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } cc_flags_t;

  typedef struct packed {
    logic lt;
    logic le;
    logic eq;
    logic ne;
    logic ge;
    logic gt;
    logic ltu;
    logic leu;
    logic geu;
    logic gtu;
  } cc_cmp_t;
endpackage

// File: rtl/addsub_operand.sv
module addsub_operand #(
  parameter int W = 32
) (
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] b_eff_o
);
  assign b_eff_o = b_i ^ {W{sub_i}};
endmodule

// File: rtl/addsub_carry_net.sv
module addsub_carry_net #(
  parameter int W   = 32,
  parameter int GRP = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam int NG = W / GRP;

  logic [W-1:0]  p, g;
  logic [NG-1:0] grp_g, grp_p;
  logic [NG:0]   grp_c;

  assign p = x_i ^ y_i;
  assign g = x_i & y_i;

  if (W % GRP != 0) begin : g_bad_width
    $error("addsub_carry_net: W must be a multiple of GRP");
  end

  for (genvar gi = 0; gi < NG; gi++) begin : g_grp
    logic          gg, gp;
    logic [GRP-1:0] s_loc;

    // group generate/propagate, independent of carry-in
    always_comb begin
      logic acc_g, acc_p;
      acc_g = 1'b0;
      acc_p = 1'b1;
      for (int j = 0; j < GRP; j++) begin
        acc_g = g[gi*GRP+j] | (p[gi*GRP+j] & acc_g);
        acc_p = acc_p & p[gi*GRP+j];
      end
      gg = acc_g;
      gp = acc_p;
    end

    // in-group lookahead: carry into bit j from prefix (G,P) and group carry
    always_comb begin
      logic pre_g, pre_p, cj;
      pre_g = 1'b0;
      pre_p = 1'b1;
      for (int j = 0; j < GRP; j++) begin
        cj       = pre_g | (pre_p & grp_c[gi]);
        s_loc[j] = p[gi*GRP+j] ^ cj;
        pre_g    = g[gi*GRP+j] | (p[gi*GRP+j] & pre_g);
        pre_p    = pre_p & p[gi*GRP+j];
      end
    end

    assign grp_g[gi]             = gg;
    assign grp_p[gi]             = gp;
    assign sum_o[gi*GRP +: GRP]  = s_loc;
  end

  always_comb begin
    grp_c[0] = cin_i;
    for (int k = 0; k < NG; k++) begin
      grp_c[k+1] = grp_g[k] | (grp_p[k] & grp_c[k]);
    end
  end

  assign cout_o = grp_c[NG];
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
  import addsub_cc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_eff_i,
  input  logic [W-1:0] res_i,
  input  logic         cout_i,
  output cc_flags_t    flags_o
);
  assign flags_o.z = ~|res_i;
  assign flags_o.n = res_i[W-1];
  assign flags_o.c = cout_i;
  // overflow on the operand actually fed to the adder
  assign flags_o.v = (a_i[W-1] ~^ b_eff_i[W-1]) & (res_i[W-1] ^ a_i[W-1]);
endmodule

// File: rtl/addsub_compare.sv
module addsub_compare
  import addsub_cc_pkg::*;
(
  input  cc_flags_t flags_i,
  output cc_cmp_t   cmp_o
);
  logic slt, ule;
  assign slt = flags_i.n ^ flags_i.v;
  assign ule = ~flags_i.c | flags_i.z;

  assign cmp_o.lt  = slt;
  assign cmp_o.le  = flags_i.z | slt;
  assign cmp_o.eq  = flags_i.z;
  assign cmp_o.ne  = ~flags_i.z;
  assign cmp_o.ge  = ~slt;
  assign cmp_o.gt  = ~(flags_i.z | slt);
  assign cmp_o.ltu = ~flags_i.c;
  assign cmp_o.leu = ule;
  assign cmp_o.geu = flags_i.c;
  assign cmp_o.gtu = ~ule;
endmodule

// File: rtl/addsub_cc.sv
module addsub_cc
  import addsub_cc_pkg::*;
#(
  parameter int W   = 32,
  parameter int GRP = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         z_o,
  output logic         n_o,
  output logic         c_o,
  output logic         v_o,
  output logic         lt_o,
  output logic         le_o,
  output logic         eq_o,
  output logic         ne_o,
  output logic         ge_o,
  output logic         gt_o,
  output logic         ltu_o,
  output logic         leu_o,
  output logic         geu_o,
  output logic         gtu_o
);
  logic [W-1:0] b_eff, sum;
  logic         cout;
  cc_flags_t    flags;
  cc_cmp_t      cmp;

  addsub_operand #(.W(W)) u_operand (
    .b_i     (b_i),
    .sub_i   (sub_i),
    .b_eff_o (b_eff)
  );

  addsub_carry_net #(.W(W), .GRP(GRP)) u_carry (
    .x_i    (a_i),
    .y_i    (b_eff),
    .cin_i  (sub_i),
    .sum_o  (sum),
    .cout_o (cout)
  );

  addsub_flags #(.W(W)) u_flags (
    .a_i     (a_i),
    .b_eff_i (b_eff),
    .res_i   (sum),
    .cout_i  (cout),
    .flags_o (flags)
  );

  addsub_compare u_cmp (
    .flags_i (flags),
    .cmp_o   (cmp)
  );

  assign res_o = sum;
  assign z_o   = flags.z;
  assign n_o   = flags.n;
  assign c_o   = flags.c;
  assign v_o   = flags.v;
  assign lt_o  = cmp.lt;
  assign le_o  = cmp.le;
  assign eq_o  = cmp.eq;
  assign ne_o  = cmp.ne;
  assign ge_o  = cmp.ge;
  assign gt_o  = cmp.gt;
  assign ltu_o = cmp.ltu;
  assign leu_o = cmp.leu;
  assign geu_o = cmp.geu;
  assign gtu_o = cmp.gtu;
endmodule

// File: rtl/addsub_cc_chk.sv
module addsub_cc_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         sub_i,
  input logic [W-1:0] res_o,
  input logic         z_o,
  input logic         v_o,
  input logic         lt_o,
  input logic         eq_o,
  input logic         ltu_o
);
  always_comb begin
    AST_ADD_SUM:   assert (sub_i || res_o == W'(a_i + b_i));                      // R1
    AST_SUB_DIFF:  assert (!sub_i || res_o == W'(a_i - b_i));                     // R2
    AST_ZERO_FLAG: assert (!z_o || res_o == '0);                                  // R3
    AST_OVF_SIGNS: assert (!v_o || (a_i[W-1] == (b_i[W-1] ^ sub_i)));             // R6
    AST_SIGNED_LT: assert (!sub_i || lt_o == ($signed(a_i) < $signed(b_i)));      // R7
    AST_EQ_MATCH:  assert (!sub_i || eq_o == (a_i == b_i));                       // R8
    AST_LTU_ORDER: assert (!sub_i || ltu_o == (a_i < b_i));                       // R9
  end
endmodule

bind addsub_cc addsub_cc_chk #(.W(W)) u_addsub_cc_chk (
  .a_i   (a_i),
  .b_i   (b_i),
  .sub_i (sub_i),
  .res_o (res_o),
  .z_o   (z_o),
  .v_o   (v_o),
  .lt_o  (lt_o),
  .eq_o  (eq_o),
  .ltu_o (ltu_o)
);

// File: tb/addsub_cc_bench.sv
module addsub_cc_bench;
  localparam int WW = 32;
  localparam int WN = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  int n_cmp = 0;
  int n_bad = 0;

  // wide instance
  logic [WW-1:0] a_w = '0, b_w = '0, r_w;
  logic s_w = 1'b0;
  logic zw, nw, cw, vw, ltw, lew, eqw, new_, gew, gtw, ltuw, leuw, geuw, gtuw;
  // narrow instance
  logic [WN-1:0] a_n = '0, b_n = '0, r_n;
  logic s_n = 1'b0;
  logic zn, nn, cn, vn, ltn, len, eqn, nen, gen_, gtn, ltun, leun, geun, gtun;

  addsub_cc #(.W(WW), .GRP(4)) u_addsub_cc (
    .a_i(a_w), .b_i(b_w), .sub_i(s_w), .res_o(r_w),
    .z_o(zw), .n_o(nw), .c_o(cw), .v_o(vw),
    .lt_o(ltw), .le_o(lew), .eq_o(eqw), .ne_o(new_), .ge_o(gew), .gt_o(gtw),
    .ltu_o(ltuw), .leu_o(leuw), .geu_o(geuw), .gtu_o(gtuw)
  );

  addsub_cc #(.W(WN), .GRP(4)) u_addsub_cc_n4 (
    .a_i(a_n), .b_i(b_n), .sub_i(s_n), .res_o(r_n),
    .z_o(zn), .n_o(nn), .c_o(cn), .v_o(vn),
    .lt_o(ltn), .le_o(len), .eq_o(eqn), .ne_o(nen), .ge_o(gen_), .gt_o(gtn),
    .ltu_o(ltun), .leu_o(leun), .geu_o(geun), .gtu_o(gtun)
  );

  typedef struct {
    bit          narrow;
    bit          sub;
    logic [31:0] res;
    bit          z, n, c, v;
    bit [9:0]    cmp;  // {lt,le,eq,ne,ge,gt,ltu,leu,geu,gtu}
  } exp_t;

  exp_t sb_q[$];

  function automatic void model(input int w, input longint unsigned a, input longint unsigned b,
                                input bit sub, output exp_t e);
    longint unsigned mask, bb, sum;
    longint sa, sb, tv, lim;
    mask = (64'd1 << w) - 1;
    bb   = sub ? (~b & mask) : b;
    sum  = a + bb + (sub ? 64'd1 : 64'd0);
    e.sub = sub;
    e.res = 32'(sum & mask);
    e.c   = ((sum >> w) & 1) != 0;
    e.z   = (sum & mask) == 0;
    e.n   = (((sum & mask) >> (w - 1)) & 1) != 0;
    sa  = longint'(a) - ((((a >> (w - 1)) & 1) != 0) ? (longint'(1) << w) : 0);
    sb  = longint'(b) - ((((b >> (w - 1)) & 1) != 0) ? (longint'(1) << w) : 0);
    tv  = sub ? sa - sb : sa + sb;
    lim = longint'(1) << (w - 1);
    e.v = (tv >= lim) || (tv < -lim);
    e.cmp = {sa < sb, sa <= sb, a == b, a != b, sa >= sb, sa > sb,
             a < b, a <= b, a >= b, a > b};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint unsigned act,
                     input longint unsigned exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: apply at posedge, push expectation
  task automatic drive(input bit narrow, input logic [31:0] a, input logic [31:0] b, input bit sub);
    exp_t e;
    @(posedge clk);
    if (narrow) begin
      a_n = a[WN-1:0]; b_n = b[WN-1:0]; s_n = sub;
      model(WN, longint'(a[WN-1:0]), longint'(b[WN-1:0]), sub, e);
    end else begin
      a_w = a; b_w = b; s_w = sub;
      model(WW, longint'(a), longint'(b), sub, e);
    end
    e.narrow = narrow;
    sb_q.push_back(e);
  endtask

  // monitor: sample at negedge, compare
  always @(negedge clk) begin
    if (rst_ni && sb_q.size() > 0) begin
      exp_t e;
      logic [31:0] r;
      logic z, n, c, v;
      logic [9:0] cm;
      e = sb_q.pop_front();
      if (e.narrow) begin
        r = 32'(r_n); z = zn; n = nn; c = cn; v = vn;
        cm = {ltn, len, eqn, nen, gen_, gtn, ltun, leun, geun, gtun};
      end else begin
        r = r_w; z = zw; n = nw; c = cw; v = vw;
        cm = {ltw, lew, eqw, new_, gew, gtw, ltuw, leuw, geuw, gtuw};
      end
      chk(r == e.res, e.sub ? "R2 result (R10)" : "R1 result (R10)", r, e.res);
      chk(z == e.z, "R3 zero", z, e.z);
      chk(n == e.n, "R4 negative", n, e.n);
      chk(c == e.c, "R5 carry", c, e.c);
      chk(v == e.v, "R6 overflow", v, e.v);
      if (e.sub) begin
        chk({cm[9:8], cm[5:4]} == {e.cmp[9:8], e.cmp[5:4]}, "R7 signed compare",
            {cm[9:8], cm[5:4]}, {e.cmp[9:8], e.cmp[5:4]});
        chk(cm[7:6] == e.cmp[7:6], "R8 eq/ne", cm[7:6], e.cmp[7:6]);
        chk(cm[3:0] == e.cmp[3:0], "R9 unsigned compare", cm[3:0], e.cmp[3:0]);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // R10: exhaustive narrow sweep, both modes
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          drive(1'b1, 32'(a), 32'(b), s[0]);
    // wide corners: R5 carry chain, R6 sign boundary, R8 equality
    drive(1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
    drive(1'b0, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0);
    drive(1'b0, 32'h8000_0000, 32'h8000_0000, 1'b0);
    drive(1'b0, 32'h8000_0000, 32'h0000_0001, 1'b1);
    drive(1'b0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    drive(1'b0, 32'h1234_5678, 32'h1234_5678, 1'b1);
    drive(1'b0, 32'h0000_0000, 32'h0000_0000, 1'b1);
    drive(1'b0, 32'h0000_0000, 32'h8000_0000, 1'b1);
    drive(1'b0, 32'h0000_FFFF, 32'h0000_0001, 1'b0);
    drive(1'b0, 32'h00FF_FFFF, 32'hFF00_0001, 1'b0);
    for (int k = 0; k < 8; k++)
      drive(1'b0, (32'd1 << (4 * k)) - 1, 32'd1, 1'b0);
    for (int i = 0; i < 3000; i++)
      drive(1'b0, $urandom, $urandom, i[0]);
    for (int i = 0; i < 500; i++) begin
      logic [31:0] x;
      x = $urandom;
      drive(1'b0, x, (i % 3 == 0) ? x : (x ^ (32'd1 << (i % 32))), 1'b1);
    end
    repeat (4) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule